// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block turns logical delay-line addresses into physical addresses for one shared, synchronous single-port sample RAM that holds several delay buffers. Each buffer has a fixed base address chosen when the program is built. Stored samples are never moved. A single base counter steps down by one at every sample-period strobe, and every access adds that counter to its logical address. Because of this, every buffer appears to shift by one slot per sample, with no data movement and no pointer per buffer.

A program writes the new sample at a buffer's first slot (logical offset 0). It reads the delayed sample from the buffer's end slot (logical offset `length`). A buffer of `length` therefore takes `length`+1 slots, so its end slot is never overwritten in the same sample period. A value written at the start comes out at the end exactly `length` sample periods later; for example, 100 samples at a 10 kHz sample rate is a 10 ms delay. The block contains a RAM model. The RAM depth is a power of two, so the address sum wraps by discarding the carry.

Top module: `dly_addr_gen`

## Requirements
- R1: After reset the base counter is zero, so the first access after reset uses a physical address equal to its logical address. All strobes are low, and `rdata_o` is zero.
- R2: Each cycle with `sample_start_i` high decrements the base counter by exactly one at that clock edge. Other cycles leave it unchanged. Zero steps to depth-1.
- R3: While `req_valid_i` is high, `ram_addr_o` equals (`req_laddr_i` + base counter) modulo the RAM depth in that same cycle. A request in the same cycle as `sample_start_i` uses the counter value from before the step.
- R4: `ram_we_o` is high exactly when `req_valid_i` and `req_we_i` are both high. `ram_re_o` is high exactly when `req_valid_i` is high and `req_we_i` is low. At most one strobe is high per clock, and none is high when no request is present.
- R5: Read data appear on `rdata_o` with `rdata_valid_o` high in the cycle after the read request. `rdata_valid_o` is low after a write or an idle cycle.
- R6: A read of a physical location that has not been written since reset returns zero.
- R7: A value written at logical address B in one sample period is returned by a read of logical address B+k exactly k sample periods later. Reading a buffer's end (offset `length`) therefore returns its start sample delayed by `length` periods.
- R8: Stored data never move. A read in the same sample period and at the same logical address as an earlier write returns the written value.
- R9: Address sums beyond depth-1 wrap modulo the depth, with the carry discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_start_i | input | 1 | Sample-period strobe; steps the base counter down |
| req_valid_i | input | 1 | Access request present this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_laddr_i | input | ADDR_W | Logical address (buffer base plus offset) |
| req_wdata_i | input | DATA_W | Write data |
| ram_addr_o | output | ADDR_W | Physical RAM address |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| rdata_o | output | DATA_W | Read data, one cycle after the read |
| rdata_valid_o | output | 1 | Read data valid |

## Verification
On every cycle, the assertions check the following:
- how the counter steps;
- that the gap between physical and logical address stays fixed between sample strobes;
- that the strobes are exclusive and follow the request;
- the one-cycle read-valid timing.

Only the bench scenarios can show that data come back correct. These are:
- zeros from unwritten slots;
- same-sample write-read round trips;
- the exact delay of a running buffer;
- wrap at the top of the address space under random mixed traffic.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/dly_base_ctr.sv
module dly_base_ctr #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dly_addr_sum.sv
module dly_addr_sum #(
  parameter int W = 10
) (
  input  logic [W-1:0] laddr_i,
  input  logic [W-1:0] base_i,
  output logic [W-1:0] paddr_o
);
  // carry dropped: wrap modulo 2**W
  assign paddr_o = laddr_i + base_i;
endmodule

// File: rtl/dly_sp_ram.sv
module dly_sp_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          re_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] wr_seen_q;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // per-slot written flag makes the array read as zero after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wr_seen_q <= '0;
    else if (we_i) wr_seen_q[addr_i] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) rdata_q <= wr_seen_q[addr_i] ? mem_q[addr_i] : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/dly_addr_gen.sv
module dly_addr_gen
  import dly_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_start_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_laddr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  logic [ADDR_W-1:0] base_cnt;
  logic [ADDR_W-1:0] paddr;
  acc_e              acc;

  dly_base_ctr #(.W(ADDR_W)) i_base_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (sample_start_i),
    .cnt_o  (base_cnt)
  );

  dly_addr_sum #(.W(ADDR_W)) i_addr_sum (
    .laddr_i (req_laddr_i),
    .base_i  (base_cnt),
    .paddr_o (paddr)
  );

  always_comb begin
    if (!req_valid_i)  acc = ACC_IDLE;
    else if (req_we_i) acc = ACC_WR;
    else               acc = ACC_RD;
  end

  assign ram_addr_o = paddr;
  assign ram_re_o   = (acc == ACC_RD);
  assign ram_we_o   = (acc == ACC_WR);

  dly_sp_ram #(.AW(ADDR_W), .DW(DATA_W)) i_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (paddr),
    .re_i     (ram_re_o),
    .we_i     (ram_we_o),
    .wdata_i  (req_wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rdata_valid_o)
  );
endmodule

// File: rtl/dly_addr_gen_chk.sv
module dly_addr_gen_chk #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_start_i,
  input logic          req_valid_i,
  input logic [AW-1:0] req_laddr_i,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_re_o,
  input logic          ram_we_o,
  input logic          rdata_valid_o,
  input logic [AW-1:0] base_q
);
  logic [AW-1:0] gap;
  assign gap = ram_addr_o - req_laddr_i;

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_start_i |=> base_q == $past(base_q) - 1'b1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_start_i |=> $stable(base_q));

  // R3
  gap_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && $past(req_valid_i) && !$past(sample_start_i)) |-> gap == $past(gap));

  // R4
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_re_o && ram_we_o));

  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !ram_re_o && !ram_we_o);

  // R5
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> rdata_valid_o);

  // R5
  no_rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_re_o |=> !rdata_valid_o);
endmodule

bind dly_addr_gen dly_addr_gen_chk #(.AW(ADDR_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_start_i (sample_start_i),
  .req_valid_i    (req_valid_i),
  .req_laddr_i    (req_laddr_i),
  .ram_addr_o     (ram_addr_o),
  .ram_re_o       (ram_re_o),
  .ram_we_o       (ram_we_o),
  .rdata_valid_o  (rdata_valid_o),
  .base_q         (base_cnt)
);

// File: tb/test_dly_addr_gen.sv
module test_dly_addr_gen;
  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_start = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_laddr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-1:0] ram_addr;
  logic          ram_re, ram_we;
  logic [DW-1:0] rdata;
  logic          rdata_valid;

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] cnt_m = '0;
  logic [DW-1:0] mem_m [DEPTH];

  always #10 clk = ~clk;

  dly_addr_gen #(.ADDR_W(AW), .DATA_W(DW)) i_dly_addr_gen (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_start_i (sample_start),
    .req_valid_i    (req_valid),
    .req_we_i       (req_we),
    .req_laddr_i    (req_laddr),
    .req_wdata_i    (req_wdata),
    .ram_addr_o     (ram_addr),
    .ram_re_o       (ram_re),
    .ram_we_o       (ram_we),
    .rdata_o        (rdata),
    .rdata_valid_o  (rdata_valid)
  );

  function automatic logic [AW-1:0] phys(input logic [AW-1:0] la, input logic [AW-1:0] c);
    return la + c;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check address/strobes mid-low, read result after posedge
  task automatic op(input bit v, input bit we, input logic [AW-1:0] la,
                    input logic [DW-1:0] wd, input bit st, input string dtag);
    logic [AW-1:0] pa;
    @(negedge clk);
    req_valid = v; req_we = we; req_laddr = la; req_wdata = wd; sample_start = st;
    pa = phys(la, cnt_m);
    #2;
    if (v) check("R3 addr", int'(ram_addr), int'(pa));
    check("R4 we", int'(ram_we), int'(v && we));
    check("R4 re", int'(ram_re), int'(v && !we));
    @(posedge clk);
    #2;
    if (v && we) mem_m[pa] = wd;
    check("R5 valid", int'(rdata_valid), int'(v && !we));
    if (v && !we) check(dtag, int'(rdata), int'(mem_m[pa]));
    if (st) cnt_m = cnt_m - 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 we", int'(ram_we), 0);
    check("R1 valid", int'(rdata_valid), 0);
    check("R1 rdata", int'(rdata), 0);
    rst_n = 1'b1;

    // R1 first access uses counter zero
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_laddr = 10'd5;
    #2;
    check("R1 first addr", int'(ram_addr), 5);
    // R6 unwritten reads zero
    op(1, 0, 10'd5,   '0, 0, "R6 zero");
    op(1, 0, 10'd900, '0, 0, "R6 zero");
    op(0, 0, '0, '0, 0, "R4 idle");

    // R8 same-sample round trip
    op(1, 1, 10'd40, 16'hBEEF, 0, "");
    op(1, 0, 10'd40, '0, 0, "R8 same sample");
    check("R8 explicit", int'(rdata), 16'hBEEF);
    op(1, 1, 10'd41, 16'h1234, 0, "");
    op(0, 0, '0, '0, 0, "");
    check("R5 valid after idle", int'(rdata_valid), 0);

    // R2/R9 counter wraps 0 -> DEPTH-1, address wraps
    op(1, 0, 10'd0, '0, 1, "R2 pre-step");
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_laddr = 10'd0; sample_start = 1'b0;
    #2;
    check("R2 wrap addr", int'(ram_addr), DEPTH - 1);
    op(1, 0, 10'd41, '0, 0, "R2 shift");
    // data at physical 41 now appears at logical 42
    op(1, 0, 10'd42, '0, 0, "R7 shift one");
    check("R7 explicit shift", int'(rdata), 16'h1234);
    // R9 sum beyond top wraps
    op(1, 1, 10'd1023, 16'h0A0A, 0, "");
    op(1, 0, 10'd1023, '0, 0, "R9 wrap data");
    check("R9 wrap addr", int'(phys(10'd1023, cnt_m)), 1022);

    // R3 request together with sample strobe uses pre-step counter
    op(1, 1, 10'd300, 16'h0777, 1, "");
    op(1, 0, 10'd301, '0, 0, "R3 pre-step");
    check("R3 explicit", int'(rdata), 16'h0777);

    // R7 running buffer: base 100, length 7, slots 8
    for (int s = 0; s < 40; s++) begin
      op(1, 0, 10'd107, '0, 0, "R7 delay");
      if (s >= 7) check("R7 explicit delay", int'(rdata), 1000 + s - 7);
      op(1, 1, 10'd100, DW'(1000 + s), 1, "");
    end

    // random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      bit v, w, st;
      v  = ($urandom % 8) != 0;
      w  = ($urandom % 2) != 0;
      st = ($urandom % 5) == 0;
      op(v, w, AW'($urandom), DW'($urandom), st, "R7 random data");
    end
    op(0, 0, '0, '0, 0, "");
    finish_run();
  end
endmodule